// File: doc/BRIEF.md
# Delay-Line Phase Search-and-Track Controller

This block closes a digital loop around a tapped delay line. It drives a 9-bit delay setting and reads back a quantized phase value from an external detector. The loop moves the setting until the measured phase sits at a programmed target, and then keeps it there. Full scale on the phase input is 16, which stands for half a clock period. One delay step is about 2 ps, and the legal settings run from 0 to 432.

Raising `enable` starts a search. The search begins at a programmable start code and moves one code per valid phase sample. It stays out of a guard band at each end of the delay range. It treats low phase readings, up to a programmable limit, as a forbidden zone. When the target has been seen on enough consecutive samples, the block raises `locked` and changes to single-step tracking. If the phase moves far from the target and stays there, the block falls back to searching. A search that reaches both guard bands raises `search_fail`. Dropping `enable` returns the block to idle, with the start code loaded.

Top module: `phase_track_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `delay_code` equals `start_code` limited to at most 432, and `locked` and `search_fail` are 0.
- R2: A clock edge with `enable` low puts the block in idle. From the next cycle, `delay_code` shows the limited start code and both flags are 0. An edge with `enable` high while idle starts a search.
- R3: `delay_code` never exceeds 432.
- R4: During a search, each edge with `meas_valid` high moves `delay_code` by exactly one code, unless the sample matches or is blocked. The phase is "low" when `meas_phase` < `target_phase` or `meas_phase` <= `keepout_max`. With `slope_neg`=0 a low phase steps up and any other phase steps down. `slope_neg`=1 swaps the two, and so does a pending guard reversal. An edge with `meas_valid` low changes nothing.
- R5: A sample with `meas_phase` <= `keepout_max` never counts toward lock, so `locked` never rises while the phase is in that zone.
- R6: A sample matches when `meas_phase` equals `target_phase` and lies outside the keep-out zone. A matching sample holds the code. On the fourth consecutive matching valid sample, `locked` goes to 1 on the following cycle. A non-matching valid sample restarts the count.
- R7: The guard width `guard_width` is limited to 216. A search step that would take the code above 432−width or below width is blocked. The first blocked step only reverses the search direction. The second blocked step raises `search_fail` on the next cycle. The flag then stays high with the code frozen until `enable` falls.
- R8: While locked, a valid sample with `meas_phase` equal to `target_phase` holds the code. Any other valid sample moves the code by one in the R4 direction (with no guard reversal), limited to the range 0 to 432.
- R9: While locked, the block counts valid samples with |`meas_phase` − `target_phase`| > 2. When 8 such samples arrive in a row, `locked` drops on the next cycle, the eighth sample does not move the code, and a fresh search starts with no guard reversal pending.
- R10: `locked` and `search_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the loop; low returns to idle |
| meas_valid | input | 1 | Phase sample strobe |
| meas_phase | input | 5 | Quantized measured phase, 0..16 |
| target_phase | input | 5 | Phase to settle at (default use 6) |
| slope_neg | input | 1 | 1 when phase falls as delay grows |
| keepout_max | input | 5 | Upper end of forbidden phase zone (default use 2) |
| start_code | input | 9 | Initial delay code for a search |
| guard_width | input | 9 | Width of the guard band at each end of the range |
| delay_code | output | 9 | Delay line setting, 0..432 |
| locked | output | 1 | Loop is locked and tracking |
| search_fail | output | 1 | Search reached both guard bands |

## Verification
Every result comes from one register stage. A phase sample presented before a rising edge, whether it steps the code, completes a lock run, completes an unlock run or hits a guard, shows on the ports right after that edge. The flags and the code therefore move in the same cycle. The bench drives inputs and samples outputs on the falling edge, half a period after the edge that uses the inputs. It compares every cycle against a behavioural model that applies the same one-edge rule. The directed checks (a step count after seven far samples, the drop after the eighth, the idle state one edge after `enable` falls) are timed from that same rule.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int CODE_W   = 9;
    localparam int PHASE_W  = 5;
    localparam int CODE_TOP = 432;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2,
        ST_FAIL   = 2'd3
    } ptc_state_e;

    // Allowed search window after guard bands are removed
    typedef struct packed {
        code_t lo;
        code_t hi;
    } ptc_window_t;

    // Per-sample verdict on the current phase reading
    typedef struct packed {
        logic match;      // on target and outside keep-out
        logic exact;      // on target
        logic far;        // error beyond tolerance
        logic up_track;   // preferred direction, no reversal
        logic up_search;  // direction including guard reversal
        logic blocked;    // search step would enter a guard band
    } ptc_decision_t;

    function automatic code_t clamp_code(input code_t c, input code_t top);
        return (c > top) ? top : c;
    endfunction

    function automatic phase_t phase_dist(input phase_t a, input phase_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/ptc_guard_window.sv
module ptc_guard_window
    import ptc_pkg::*;
#(
    parameter int CODE_MAX = ptc_pkg::CODE_TOP
) (
    input  code_t       guard_width,
    output ptc_window_t win
);
    localparam code_t MAX_C  = code_t'(CODE_MAX);
    localparam code_t HALF_C = code_t'(CODE_MAX / 2);

    code_t g_lim;

    always_comb begin
        g_lim  = (guard_width > HALF_C) ? HALF_C : guard_width;
        win.lo = g_lim;
        win.hi = MAX_C - g_lim;
    end
endmodule

// File: rtl/ptc_decide.sv
module ptc_decide
    import ptc_pkg::*;
#(
    parameter int ERR_TOL = 2
) (
    input  phase_t        meas,
    input  phase_t        target,
    input  phase_t        keepout,
    input  logic          slope_neg,
    input  logic          flipped,
    input  code_t         code,
    input  ptc_window_t   win,
    output ptc_decision_t dec
);
    logic in_keep;
    logic low;

    always_comb begin
        in_keep       = (meas <= keepout);
        low           = in_keep || (meas < target);
        dec.exact     = (meas == target);
        dec.match     = dec.exact && !in_keep;
        dec.far       = phase_dist(meas, target) > phase_t'(ERR_TOL);
        dec.up_track  = low ^ slope_neg;
        dec.up_search = dec.up_track ^ flipped;
        dec.blocked   = dec.up_search ? (code >= win.hi) : (code <= win.lo);
    end
endmodule

// File: rtl/ptc_run_counter.sv
module ptc_run_counter #(
    parameter int RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    input  logic hit,
    output logic full
);
    localparam int W = $clog2(RUN + 1);

    logic [W-1:0] cnt_q;

    assign full = !clr && adv && hit && (cnt_q == W'(RUN - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            if (!hit || full) cnt_q <= '0;
            else              cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/phase_track_ctrl.sv
module phase_track_ctrl
    import ptc_pkg::*;
#(
    parameter int CODE_MAX   = ptc_pkg::CODE_TOP,
    parameter int LOCK_RUN   = 4,
    parameter int UNLOCK_RUN = 8,
    parameter int ERR_TOL    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                meas_valid,
    input  logic [PHASE_W-1:0]  meas_phase,
    input  logic [PHASE_W-1:0]  target_phase,
    input  logic                slope_neg,
    input  logic [PHASE_W-1:0]  keepout_max,
    input  logic [CODE_W-1:0]   start_code,
    input  logic [CODE_W-1:0]   guard_width,
    output logic [CODE_W-1:0]   delay_code,
    output logic                locked,
    output logic                search_fail
);
    localparam code_t MAX_C = code_t'(CODE_MAX);

    ptc_state_e    state_q;
    code_t         code_q;
    logic          flip_q;
    ptc_window_t   win;
    ptc_decision_t dec;
    code_t         start_c;
    code_t         track_next;
    logic          lock_full;
    logic          drop_full;
    logic          in_search;
    logic          in_track;

    assign start_c   = clamp_code(start_code, MAX_C);
    assign in_search = (state_q == ST_SEARCH);
    assign in_track  = (state_q == ST_TRACK);

    ptc_guard_window #(.CODE_MAX(CODE_MAX)) u_win (
        .guard_width (guard_width),
        .win         (win)
    );

    ptc_decide #(.ERR_TOL(ERR_TOL)) u_dec (
        .meas      (meas_phase),
        .target    (target_phase),
        .keepout   (keepout_max),
        .slope_neg (slope_neg),
        .flipped   (flip_q),
        .code      (code_q),
        .win       (win),
        .dec       (dec)
    );

    ptc_run_counter #(.RUN(LOCK_RUN)) u_lock_run (
        .clk  (clk),
        .rst  (rst),
        .clr  (!enable || !in_search),
        .adv  (meas_valid && in_search),
        .hit  (dec.match),
        .full (lock_full)
    );

    ptc_run_counter #(.RUN(UNLOCK_RUN)) u_drop_run (
        .clk  (clk),
        .rst  (rst),
        .clr  (!enable || !in_track),
        .adv  (meas_valid && in_track),
        .hit  (dec.far),
        .full (drop_full)
    );

    // Single step toward the preferred direction, held at range ends
    always_comb begin
        track_next = code_q;
        if (dec.up_track && (code_q != MAX_C))
            track_next = code_q + code_t'(1);
        else if (!dec.up_track && (code_q != '0))
            track_next = code_q - code_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q <= ST_IDLE;
            code_q  <= start_c;
            flip_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_SEARCH;
                    flip_q  <= 1'b0;
                end
                ST_SEARCH: begin
                    if (meas_valid) begin
                        if (dec.match) begin
                            if (lock_full) state_q <= ST_TRACK;
                        end else if (dec.blocked) begin
                            if (flip_q) state_q <= ST_FAIL;
                            else        flip_q  <= 1'b1;
                        end else if (dec.up_search) begin
                            code_q <= code_q + code_t'(1);
                        end else begin
                            code_q <= code_q - code_t'(1);
                        end
                    end
                end
                ST_TRACK: begin
                    if (meas_valid) begin
                        if (drop_full) begin
                            state_q <= ST_SEARCH;
                            flip_q  <= 1'b0;
                        end else if (!dec.exact) begin
                            code_q <= track_next;
                        end
                    end
                end
                default: begin
                    state_q <= ST_FAIL;
                end
            endcase
        end
    end

    assign delay_code  = code_q;
    assign locked      = in_track;
    assign search_fail = (state_q == ST_FAIL);

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       meas_valid,
    input logic [4:0] meas_phase,
    input logic [4:0] target_phase,
    input logic [4:0] keepout_max,
    input logic [8:0] delay_code,
    input logic       locked,
    input logic       search_fail
);
    assert_code_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        delay_code <= 9'd432);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(locked && search_fail));

    assert_idle_on_disable_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!locked && !search_fail));

    assert_no_sample_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && locked && !meas_valid) |=> $stable(delay_code));

    assert_lock_outside_keepout_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(meas_valid) && ($past(meas_phase) > $past(keepout_max))));

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && search_fail) |=> (search_fail && $stable(delay_code)));

    assert_track_single_step_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && locked) |=> ((delay_code == $past(delay_code)) ||
                                (delay_code == $past(delay_code) + 9'd1) ||
                                (delay_code + 9'd1 == $past(delay_code))));

    assert_track_hold_on_target_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && locked && meas_valid && (meas_phase == target_phase)) |=> $stable(delay_code));
endmodule

bind phase_track_ctrl ptc_checker u_ptc_checker (.*);

// File: tb/tb_phase_track_ctrl.sv
module tb_phase_track_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic       meas_valid;
    logic [4:0] meas_phase;
    logic [4:0] target_phase;
    logic       slope_neg;
    logic [4:0] keepout_max;
    logic [8:0] start_code;
    logic [8:0] guard_width;
    logic [8:0] delay_code;
    logic       locked;
    logic       search_fail;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit chk_on = 1'b0;
    bit auto_drv = 1'b0;
    int plant = 0;

    // Reference model state: 0 idle, 1 search, 2 track, 3 fail
    int m_state, m_code, m_flip, m_mc, m_fc;

    always #2 clk = ~clk;

    phase_track_ctrl dut (
        .clk(clk), .rst(rst), .enable(enable), .meas_valid(meas_valid),
        .meas_phase(meas_phase), .target_phase(target_phase), .slope_neg(slope_neg),
        .keepout_max(keepout_max), .start_code(start_code), .guard_width(guard_width),
        .delay_code(delay_code), .locked(locked), .search_fail(search_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int phase_of(input int kind, input int code);
        int p;
        case (kind)
            0:       p = code / 8;
            1:       p = (432 - code) / 8;
            default: p = code / 32;
        endcase
        return (p > 16) ? 16 : p;
    endfunction

    always @(posedge clk) begin : ref_model
        int sc, g, lo, hi, low, upd, u, err, matchv, far;
        cyc++;
        sc  = (start_code > 432) ? 432 : int'(start_code);
        g   = (guard_width > 216) ? 216 : int'(guard_width);
        lo  = g;
        hi  = 432 - g;
        if (rst || !enable) begin
            m_state = 0; m_code = sc; m_flip = 0; m_mc = 0; m_fc = 0;
        end else begin
            err    = int'(meas_phase) - int'(target_phase);
            low    = (meas_phase <= keepout_max) || (meas_phase < target_phase);
            upd    = low ^ int'(slope_neg);
            matchv = (err == 0) && (meas_phase > keepout_max);
            far    = (err > 2) || (err < -2);
            case (m_state)
                0: begin m_state = 1; m_flip = 0; m_mc = 0; m_fc = 0; end
                1: if (meas_valid) begin
                    if (matchv) begin
                        m_mc++;
                        if (m_mc == 4) begin m_state = 2; m_mc = 0; m_fc = 0; end
                    end else begin
                        m_mc = 0;
                        u = upd ^ m_flip;
                        if ((u != 0 && m_code >= hi) || (u == 0 && m_code <= lo)) begin
                            if (m_flip != 0) m_state = 3;
                            else m_flip = 1;
                        end else begin
                            m_code = (u != 0) ? m_code + 1 : m_code - 1;
                        end
                    end
                end
                2: if (meas_valid) begin
                    if (far) begin
                        m_fc++;
                        if (m_fc == 8) begin m_state = 1; m_flip = 0; m_fc = 0; m_mc = 0; end
                    end else begin
                        m_fc = 0;
                    end
                    if (m_state == 2 && err != 0) begin
                        if (upd != 0 && m_code < 432) m_code++;
                        else if (upd == 0 && m_code > 0) m_code--;
                    end
                end
                default: ;
            endcase
        end
        if (cyc >= 150000) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Compare against the model, then drive the automatic phase source
    always @(negedge clk) begin
        if (chk_on) begin
            chk(delay_code == m_code, "R4 R8 code vs model", delay_code, m_code);
            chk(locked == (m_state == 2), "R6 R9 lock vs model", locked, m_state == 2);
            chk(search_fail == (m_state == 3), "R7 fail vs model", search_fail, m_state == 3);
            chk(!(locked && search_fail), "R10 exclusive flags", locked + search_fail, 1);
            chk(delay_code <= 432, "R3 range", delay_code, 432);
        end
        if (auto_drv) begin
            meas_valid = (cyc % 3) != 2;
            meas_phase = 5'(phase_of(plant, delay_code));
        end
    end

    task automatic wait_flag(input bit want_fail, input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (want_fail ? search_fail : locked) break;
        end
    endtask

    task automatic drop_enable();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int code0, lo_seen, hi_seen, lock_seen;
        rst = 1'b1; enable = 1'b0; meas_valid = 1'b0; meas_phase = '0;
        target_phase = 5'd6; slope_neg = 1'b0; keepout_max = 5'd2;
        start_code = 9'd500; guard_width = 9'd20;
        repeat (4) @(negedge clk);
        chk_on = 1'b1;
        chk(delay_code == 432, "R1 reset code limited", delay_code, 432);
        chk(!locked && !search_fail, "R1 reset flags", locked + search_fail, 0);
        rst = 1'b0;
        start_code = 9'd200;
        @(negedge clk);
        chk(delay_code == 200, "R1 R2 start code loaded", delay_code, 200);

        // Positive slope lock
        plant = 0; auto_drv = 1'b1; enable = 1'b1;
        wait_flag(1'b0, 2000);
        chk(locked == 1'b1, "R6 lock acquired", locked, 1);
        chk(phase_of(0, delay_code) == 6, "R6 locked at target", phase_of(0, delay_code), 6);
        code0 = delay_code;
        repeat (20) @(negedge clk);
        chk(delay_code == code0, "R8 hold on target", delay_code, code0);

        // Far error: seven steps, then unlock on eighth
        auto_drv = 1'b0;
        for (int i = 0; i < 7; i++) begin
            meas_valid = 1'b1; meas_phase = 5'd12;
            @(negedge clk);
        end
        meas_valid = 1'b0;
        @(negedge clk);
        chk(delay_code == code0 - 7, "R8 single steps while far", delay_code, code0 - 7);
        chk(locked == 1'b1, "R9 still locked after 7", locked, 1);
        meas_valid = 1'b1; meas_phase = 5'd12;
        @(negedge clk);
        meas_valid = 1'b0;
        chk(locked == 1'b0, "R9 unlocked after 8", locked, 0);
        chk(delay_code == code0 - 7, "R9 no step on 8th", delay_code, code0 - 7);
        auto_drv = 1'b1;
        wait_flag(1'b0, 2000);
        chk(locked == 1'b1, "R9 relock after search", locked, 1);

        // Disable returns to idle
        drop_enable();
        chk(!locked && delay_code == 200, "R2 idle after disable", delay_code, 200);

        // Negative slope
        slope_neg = 1'b1; plant = 1;
        @(negedge clk);
        enable = 1'b1;
        wait_flag(1'b0, 2000);
        chk(locked == 1'b1, "R4 negative slope lock", locked, 1);
        chk(phase_of(1, delay_code) == 6, "R4 negative slope phase", phase_of(1, delay_code), 6);

        // Keep-out: target inside the forbidden zone never locks
        drop_enable();
        slope_neg = 1'b0; plant = 2; target_phase = 5'd2; keepout_max = 5'd3;
        start_code = 9'd64; guard_width = 9'd10;
        @(negedge clk);
        enable = 1'b1;
        lock_seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (locked) lock_seen = 1;
        end
        chk(lock_seen == 0, "R5 no lock in keep-out", lock_seen, 0);

        // Unreachable target: reversal then failure
        drop_enable();
        target_phase = 5'd16; keepout_max = 5'd2; start_code = 9'd200; guard_width = 9'd40;
        @(negedge clk);
        enable = 1'b1;
        lo_seen = 432; hi_seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (delay_code < lo_seen) lo_seen = delay_code;
            if (delay_code > hi_seen) hi_seen = delay_code;
            if (search_fail) break;
        end
        chk(search_fail == 1'b1, "R7 fail raised", search_fail, 1);
        chk(hi_seen == 392, "R7 upper guard respected", hi_seen, 392);
        chk(lo_seen == 40, "R7 lower guard respected", lo_seen, 40);
        code0 = delay_code;
        repeat (30) @(negedge clk);
        chk(search_fail && delay_code == code0, "R7 fail held", delay_code, code0);
        drop_enable();
        chk(!search_fail && delay_code == 200, "R2 fail cleared on disable", search_fail, 0);

        auto_drv = 1'b0;
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule